// File: doc/BRIEF.md
# Counter and Watchdog Timer with Shared Prescaler

This block holds an 8-bit free-running event counter and a watchdog timer. Both draw on a single 8-bit divider, so only one of them can be divided down at a time. A six-bit mode register chooses four things: which timer owns the divider, the divide code, whether the counter follows instruction cycles or an external pin, and which pin edge counts. The same three-bit divide code gives twice the ratio when the counter owns the divider as when the watchdog owns it. The counter then divides by 2 to 256 and the watchdog by 1 to 128.

The counter can be read and written at any time, and it raises a one-cycle pulse when it wraps. The watchdog counts a slow base tick. A fixed number of base ticks makes one base period, and each base period passes through the divider when the watchdog owns it. A clear strobe restarts the watchdog, and the surrounding core issues that strobe for its clear and sleep operations. The external pin passes through a two-flop synchronizer inside the block.

Top module: `tmr_wdt_core`

## Requirements
- R1: After reset the mode register reads 0x3F. In that state the divider belongs to the watchdog with code 7 (1:128), the counter source is the pin, the falling edge counts, the counter reads 0x00, and neither pulse output is high. Mode read-back bits 7:6 always read 0.
- R2: Mode bit 3 = 0 gives the divider to the counter. Divide code c in mode bits 2:0 then advances the counter once every 2^(c+1) counter events.
- R3: Mode bit 3 = 1 gives the divider to the watchdog. The counter then advances once on every counter event, with no division.
- R4: Mode bit 5 = 0 makes each cycle with the instruction-cycle enable high a counter event. Mode bit 5 = 1 makes each selected edge of the synchronized pin a counter event: a rising edge when mode bit 4 = 0, a falling edge when bit 4 = 1. When bit 5 = 1 the enable input has no effect.
- R5: The counter wraps from 0xFF to 0x00. `cnt_ovf` is high for exactly the one cycle in which the counter first reads 0x00 after the wrap.
- R6: A counter write loads the value on the next clock edge. It also clears the divider count, so the next divided step needs a full ratio of events.
- R7: With the divider assigned to the counter, `wdt_to` pulses for one cycle once every WDT_BASE base ticks.
- R8: With the divider assigned to the watchdog and code c, `wdt_to` pulses once every WDT_BASE*2^c base ticks.
- R9: A watchdog clear restarts the base count. It also clears the divider count when the watchdog owns the divider. No timeout pulse follows in the cycle after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, one cycle per instruction |
| ext_pin | input | 1 | External count pin, asynchronous |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode write data; bits 7:6 ignored |
| mode_q | output | 8 | Mode register read-back |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cnt_q | output | 8 | Counter value |
| cnt_ovf | output | 1 | One-cycle pulse on counter wrap |
| wdt_clr | input | 1 | Watchdog restart strobe |
| wdt_tick | input | 1 | Watchdog base tick, one cycle wide |
| wdt_to | output | 1 | One-cycle watchdog timeout pulse |

## Verification
A divider count left stale after a counter write or a watchdog clear shows up as a counter step or timeout one or more events early. That error appears within a single divide ratio of events. A wrong mask for one owner shifts every step by a factor of two, and the counter value shows it after the first 2^(c+1) events. A wrong edge or source choice changes the count after a single pin pulse or enable cycle. A base counter that does not restart moves the timeout instant, and the bench catches that by checking that no pulse arrives one tick before the expected period and one pulse arrives exactly at it.

// File: rtl/tmr_pkg.sv
// Shared types and helpers for the counter/watchdog block.
// Assumes a 3-bit divide code and an 8-bit divider.
package tmr_pkg;

    localparam int PS_W  = 3;
    localparam int PSC_W = 1 << PS_W;

    // Mode fields, packed so that bit order matches the register layout.
    typedef struct packed {
        logic            src_pin;    // bit 5: 1 = pin edges, 0 = cycle enable
        logic            edge_fall;  // bit 4: 1 = falling edge counts
        logic            to_wdt;     // bit 3: 1 = divider owned by watchdog
        logic [PS_W-1:0] code;       // bits 2:0: divide code
    } tmode_t;

    localparam tmode_t TMODE_RST = '{src_pin: 1'b1, edge_fall: 1'b1,
                                     to_wdt: 1'b1, code: 3'b111};

    // Low-bit mask whose all-ones state marks the last event of one ratio.
    function automatic logic [PSC_W-1:0] div_mask(input logic [PS_W-1:0] code,
                                                  input logic wdt_side);
        logic [PSC_W:0] one;
        logic [PS_W:0]  sh;
        sh  = wdt_side ? {1'b0, code} : ({1'b0, code} + 1'b1);
        one = (PSC_W+1)'(1) << sh;
        return PSC_W'(one - (PSC_W+1)'(1));
    endfunction

endpackage

// File: rtl/tmr_pin_edge.sv
// Pin synchronizer and edge selector.
// Two flops bring the asynchronous pin into the clock domain and a third
// holds the previous level. A one-cycle event marks the selected edge.
module tmr_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_fall,
    output logic evt
);
    logic s1, s2, s3;

    // Synchronize the pin and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Choose the transition that counts.
    always_comb begin
        evt = edge_fall ? (s3 & ~s2) : (s2 & ~s3);
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Shared binary divider. It counts advance events and reports a hit on the
// event that completes one ratio, as given by the mask. A clear zeroes the
// count and suppresses any hit in that cycle.
module tmr_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Hit when the masked count is all ones on an advance.
    always_comb begin
        hit = adv & ~clr & ((cnt & mask) == mask);
    end

    // Clear or advance the divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_wdt_base.sv
// Watchdog base period counter. It counts base ticks and flags the tick
// that completes BASE of them. A clear restarts the count, and a clear
// that arrives together with a tick wins.
// Assumes BASE >= 2.
module tmr_wdt_base #(
    parameter int BASE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic period_end
);
    localparam int W = (BASE > 2) ? $clog2(BASE) : 1;
    localparam logic [W-1:0] LAST = W'(BASE - 1);

    logic [W-1:0] cnt;

    // Flag the tick that completes one base period.
    always_comb begin
        period_end = tick & ~clr & (cnt == LAST);
    end

    // Count base ticks, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
// Loadable up-counter with a wrap pulse. A write takes priority over an
// increment. The wrap pulse is registered, so it is high in the cycle in
// which the counter first reads zero.
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         ovf
);
    // Load, increment and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            ovf <= 1'b0;
        end else if (we) begin
            q   <= wdata;
            ovf <= 1'b0;
        end else begin
            ovf <= inc & (&q);
            if (inc) begin
                q <= q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_wdt_core.sv
// Counter and watchdog with one shared divider.
// A mode register routes the divider to the counter or to the watchdog and
// selects the counter source and the pin edge. Timeouts are registered
// one-cycle pulses. All strobes are one cycle wide and synchronous to clk.
module tmr_wdt_core #(
    parameter int CNT_W    = 8,
    parameter int WDT_BASE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             mode_we,
    input  logic [7:0]       mode_wdata,
    output logic [7:0]       mode_q,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_ovf,
    input  logic             wdt_clr,
    input  logic             wdt_tick,
    output logic             wdt_to
);
    import tmr_pkg::*;

    localparam int MODE_W = $bits(tmode_t);

    tmode_t             mode;
    logic               pin_evt;
    logic               cnt_evt;
    logic               base_end;
    logic               psc_clr;
    logic               psc_adv;
    logic               psc_hit;
    logic [PSC_W-1:0]   psc_mask;
    logic               cnt_inc;

    // Mode register with its reset default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= TMODE_RST;
        end else if (mode_we) begin
            mode <= tmode_t'(mode_wdata[MODE_W-1:0]);
        end
    end

    // Read-back with the unused upper bits at zero.
    always_comb begin
        mode_q = {{(8-MODE_W){1'b0}}, mode};
    end

    tmr_pin_edge u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_pin),
        .edge_fall (mode.edge_fall),
        .evt       (pin_evt)
    );

    tmr_wdt_base #(.BASE(WDT_BASE)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (wdt_clr),
        .tick       (wdt_tick),
        .period_end (base_end)
    );

    // Route events and clears to the divider according to its owner.
    always_comb begin
        cnt_evt  = mode.src_pin ? pin_evt : cyc_en;
        psc_mask = div_mask(mode.code, mode.to_wdt);
        psc_adv  = mode.to_wdt ? base_end : cnt_evt;
        psc_clr  = cnt_we | (wdt_clr & mode.to_wdt);
        cnt_inc  = mode.to_wdt ? cnt_evt : psc_hit;
    end

    tmr_prescaler #(.W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (psc_clr),
        .adv   (psc_adv),
        .mask  (psc_mask),
        .hit   (psc_hit)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cnt_we),
        .wdata (cnt_wdata),
        .inc   (cnt_inc),
        .q     (cnt_q),
        .ovf   (cnt_ovf)
    );

    // Register the timeout: every base period, or every divided period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_to <= 1'b0;
        end else begin
            wdt_to <= base_end & (mode.to_wdt ? psc_hit : 1'b1);
        end
    end
endmodule

// File: rtl/tmr_wdt_chk.sv
// Property checker for tmr_wdt_core, attached with bind.
// It observes only the ports of the top module.
module tmr_wdt_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_we,
    input logic [7:0]       mode_q,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic             cnt_ovf,
    input logic             wdt_clr,
    input logic             wdt_to
);
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(mode_q)); // R1

    AST_MODE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_q[7:6] == 2'b00)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ovf |-> (cnt_q == '0)); // R5

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ovf |=> !cnt_ovf); // R5

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_q == $past(cnt_wdata))); // R6

    AST_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_to |=> !wdt_to); // R7

    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_to); // R9
endmodule

bind tmr_wdt_core tmr_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_q    (mode_q),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cnt_q     (cnt_q),
    .cnt_ovf   (cnt_ovf),
    .wdt_clr   (wdt_clr),
    .wdt_to    (wdt_to)
);

// File: tb/sim_tmr_wdt_core.sv
`timescale 1ns/1ps
module sim_tmr_wdt_core;
    localparam int BASE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_pin = 1'b0;
    logic       mode_we = 1'b0, cnt_we = 1'b0, wdt_clr = 1'b0, wdt_tick = 1'b0;
    logic [7:0] mode_wdata = '0, cnt_wdata = '0;
    logic [7:0] mode_q, cnt_q;
    logic       cnt_ovf, wdt_to;

    int tests = 0, fails = 0;
    int to_seen = 0, ovf_seen = 0;

    always #4 clk = ~clk;

    tmr_wdt_core #(.CNT_W(8), .WDT_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_q(mode_q),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .cnt_ovf(cnt_ovf),
        .wdt_clr(wdt_clr), .wdt_tick(wdt_tick), .wdt_to(wdt_to)
    );

    // Pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            to_seen  <= to_seen + int'(wdt_to);
            ovf_seen <= ovf_seen + int'(cnt_ovf);
        end
    end

    // Expected values, computed from the requirements.
    function automatic int exp_cnt_div(input int n, input int code);
        return (n >> (code + 1)) & 255;
    endfunction
    function automatic int exp_wdt_period(input int code, input bit to_wdt);
        return to_wdt ? (BASE << code) : BASE;
    endfunction
    function automatic logic [7:0] mode_word(input bit src_pin, input bit fall,
                                             input bit to_wdt, input int code);
        return {2'b00, src_pin, fall, to_wdt, 3'(code)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [7:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(negedge clk); mode_we = 1'b0;
    endtask
    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask
    task automatic run_cyc(input int n);
        if (n > 0) begin
            @(negedge clk); cyc_en = 1'b1;
            repeat (n) @(negedge clk);
            cyc_en = 1'b0;
        end
    endtask
    task automatic run_ticks(input int n);
        if (n > 0) begin
            @(negedge clk); wdt_tick = 1'b1;
            repeat (n) @(negedge clk);
            wdt_tick = 1'b0;
        end
    endtask
    task automatic clr_wdt();
        @(negedge clk); wdt_clr = 1'b1;
        @(negedge clk); wdt_clr = 1'b0;
    endtask
    task automatic pin_to(input logic v);
        @(negedge clk); ext_pin = v;
        repeat (5) @(negedge clk);
    endtask

    // Watchdog on the run itself.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base_to;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check("R1 mode after reset", mode_q, 8'h3F);
        check("R1 counter after reset", cnt_q, 0);
        check("R1 ovf after reset", cnt_ovf, 0);
        check("R1 timeout after reset", wdt_to, 0);

        // R4: pin source by default, so the enable is ignored.
        run_cyc(10);
        check("R4 enable ignored with pin source", cnt_q, 0);

        // R1, R8: default watchdog ratio 1:128.
        base_to = to_seen;
        run_ticks(BASE * 128 - 1); @(negedge clk);
        check("R1 no timeout before default period", to_seen - base_to, 0);
        run_ticks(1); @(negedge clk);
        check("R1 timeout at default period", to_seen - base_to, 1);

        // R1: mode write and read-back of the upper bits.
        wr_mode(8'hFF);
        check("R1 upper bits read 0", mode_q, 8'h3F);
        wr_mode(8'h12);
        check("R1 mode read-back", mode_q, 8'h12);

        // R2: counter owns the divider, random codes and lengths.
        for (int i = 0; i < 6; i++) begin
            int code, n;
            code = (i < 2) ? (i * 7) : int'($urandom_range(0, 7));
            n    = int'($urandom_range(0, 600));
            wr_mode(mode_word(0, 0, 0, code));
            wr_cnt(8'h00);
            run_cyc(n);
            check($sformatf("R2 code %0d n %0d", code, n), cnt_q, exp_cnt_div(n, code));
        end

        // R3: watchdog owns the divider, counter undivided.
        for (int i = 0; i < 3; i++) begin
            int n;
            n = int'($urandom_range(1, 300));
            wr_mode(mode_word(0, 0, 1, int'($urandom_range(0, 7))));
            wr_cnt(8'h00);
            run_cyc(n);
            check($sformatf("R3 undivided n %0d", n), cnt_q, n & 255);
        end

        // R4: pin edges, with the enable held high to show it is ignored.
        for (int fall = 0; fall < 2; fall++) begin
            int k;
            k = int'($urandom_range(3, 20));
            wr_mode(mode_word(1, fall[0], 1, 0));
            wr_cnt(8'h00);
            cyc_en = 1'b1;
            for (int j = 0; j < k; j++) begin
                pin_to(1'b1);
                if (j < k - 1) pin_to(1'b0);
            end
            cyc_en = 1'b0;
            check($sformatf("R4 edge fall=%0d pulses %0d", fall, k), cnt_q,
                  (fall == 0) ? k : k - 1);
            pin_to(1'b0);
        end

        // R5: wrap and single overflow pulse.
        wr_mode(mode_word(0, 0, 1, 0));
        wr_cnt(8'hFD);
        base_to = ovf_seen;
        run_cyc(2);
        check("R5 no ovf before wrap", cnt_q, 8'hFF);
        run_cyc(1);
        check("R5 wraps to zero", cnt_q, 0);
        check("R5 ovf high at wrap", cnt_ovf, 1);
        @(negedge clk);
        check("R5 ovf one cycle", cnt_ovf, 0);
        check("R5 one ovf pulse", ovf_seen - base_to, 1);

        // R6: counter write clears the divider count (ratio 1:8).
        wr_mode(mode_word(0, 0, 0, 2));
        wr_cnt(8'h00);
        run_cyc(5);
        wr_cnt(8'h40);
        check("R6 write loads value", cnt_q, 8'h40);
        run_cyc(7);
        check("R6 divider restarted", cnt_q, 8'h40);
        run_cyc(1);
        check("R6 full ratio after write", cnt_q, 8'h41);

        // R7, R8, R9: watchdog periods and restart.
        for (int i = 0; i < 4; i++) begin
            int code, per;
            bit own;
            own  = (i != 0);
            code = (i == 1) ? 0 : int'($urandom_range(0, 5));
            per  = exp_wdt_period(code, own);
            wr_mode(mode_word(0, 0, own, code));
            clr_wdt();
            base_to = to_seen;
            run_ticks(per - 1); @(negedge clk);
            check($sformatf("%s early own=%0d code %0d", own ? "R8" : "R7", own, code),
                  to_seen - base_to, 0);
            run_ticks(1); @(negedge clk);
            check($sformatf("%s period own=%0d code %0d", own ? "R8" : "R7", own, code),
                  to_seen - base_to, 1);
            run_ticks(per - 1);
            clr_wdt();
            run_ticks(per - 1); @(negedge clk);
            check($sformatf("R9 clear restarts own=%0d", own), to_seen - base_to, 1);
            run_ticks(1); @(negedge clk);
            check($sformatf("R9 period after clear own=%0d", own), to_seen - base_to, 2);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule